// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block is the read side of a mask-style read-only memory. One array of 16-bit words can be read either as whole words or as single bytes, and a mode input picks which. In word mode the word address selects a word, and all sixteen data lines carry it. In byte mode the topmost data line stops being an output. It becomes an extra address input below the word address, and that bit picks which half of the word appears on the low eight data lines.

The read path is purely combinational. It has no clock, no register and no handshake. The three control pins are plain levels:
- an active-low chip select;
- an active-low output gate;
- the organisation select.

Each data line is modelled as a value bit plus a drive-enable bit, which stands in for a tri-state pad. A standby flag shows when the chip select is released.

The contents come from a fixed arithmetic rule evaluated at elaboration. The depth is a parameter, so a small instance is cheap to simulate.

Top module: `rom_bw_port`

## Requirements
- R1: The word stored at word address a is (a*40503 + 4660) mod 65536. With word_mode=1, dq_out equals the word stored at addr.
- R2: With word_mode=0, the byte address is {addr, dq15_in}. If dq15_in=0, dq_out[7:0] is the low byte (bits 7..0) of the word at addr. If dq15_in=1, dq_out[7:0] is the high byte (bits 15..8). In byte mode dq_out[15:8] is 8'h00.
- R3: dq_oe[7:0] is 8'hFF when ce_n=0 and oe_n=0, and 8'h00 otherwise.
- R4: dq_oe[15:8] is 8'hFF only when word_mode=1, ce_n=0 and oe_n=0. Otherwise it is 8'h00, which means it is always 8'h00 in byte mode.
- R5: While ce_n=1, dq_oe is 16'h0000 whatever the other inputs are.
- R6: standby is 1 exactly while ce_n=1.
- R7: oe_n has no effect on dq_out or standby. It only gates dq_oe.
- R8: With word_mode=1, dq15_in has no effect on dq_out.
- R9: Every output follows a change of any input within the same clock period. There is no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ce_n | input | 1 | Chip select, active low. High puts the block in standby. |
| oe_n | input | 1 | Output gate, active low. |
| word_mode | input | 1 | Organisation select: 1 selects word access, 0 selects byte access. |
| addr | input | ADDR_W | Word address. |
| dq15_in | input | 1 | Input side of the top data line. In byte mode it is the byte-select address bit. |
| dq_out | output | 16 | Data value on each line. |
| dq_oe | output | 16 | Per-line drive enable. 0 means high impedance. |
| standby | output | 1 | High while the chip select is released. |

## Verification
Every result is due in the same period as the stimulus, because no register lies on any path from a pin to an output. The bench drives a new input combination on the falling clock edge. It samples all outputs 1 ns later, well before the next rising edge, so a design that registered any output would be caught showing the previous combination. The sweep covers every word address, with every combination of chip select, output gate, mode and top data line at each one.

// File: rtl/rom_bw_pkg.sv
package rom_bw_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    ORG_BYTE = 1'b0,
    ORG_WORD = 1'b1
  } org_e;

  typedef struct packed {
    logic lo_drive;
    logic hi_drive;
    logic stby;
  } gate_t;

  // Content rule: scrambled affine function of the word address, mod 2^16.
  function automatic logic [WORD_W-1:0] rom_word(input logic [WORD_W-1:0] a);
    logic [WORD_W-1:0] v;
    v = a * 16'd40503 + 16'd4660;
    return v;
  endfunction

endpackage

// File: rtl/rom_addr_form.sv
module rom_addr_form
  import rom_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  org_e              org,
  input  logic              lsb_in,
  output logic [ADDR_W-1:0] word_idx,
  output logic              take_hi
);

  // Byte address = {addr, lsb_in}; the word index is the byte address >> 1.
  always_comb begin
    word_idx = addr;
    take_hi  = (org == ORG_BYTE) && lsb_in;
  end

endmodule

// File: rtl/rom_array.sv
module rom_array
  import rom_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] idx,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign mem[i] = rom_word(WORD_W'(i));
  end

  assign rd_word = mem[idx];

endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
  import rom_bw_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  org_e              org,
  input  logic              take_hi,
  output logic [WORD_W-1:0] dq
);

  logic [BYTE_W-1:0] lane;

  always_comb begin
    lane = take_hi ? word_in[WORD_W-1:BYTE_W] : word_in[BYTE_W-1:0];
    if (org == ORG_WORD) dq = word_in;
    else                 dq = {{BYTE_W{1'b0}}, lane};
  end

endmodule

// File: rtl/rom_out_gate.sv
module rom_out_gate
  import rom_bw_pkg::*;
(
  input  logic              ce_n,
  input  logic              oe_n,
  input  org_e              org,
  output logic [WORD_W-1:0] oe_vec,
  output logic              standby
);

  gate_t g;

  always_comb begin
    g.stby     = ce_n;
    g.lo_drive = !ce_n && !oe_n;
    g.hi_drive = g.lo_drive && (org == ORG_WORD);
    oe_vec     = {{BYTE_W{g.hi_drive}}, {BYTE_W{g.lo_drive}}};
    standby    = g.stby;
  end

endmodule

// File: rtl/rom_bw_port.sv
module rom_bw_port
  import rom_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dq15_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic              standby
);

  org_e              org;
  logic [ADDR_W-1:0] word_idx;
  logic              take_hi;
  logic [WORD_W-1:0] rd_word;

  assign org = org_e'(word_mode);

  rom_addr_form #(.ADDR_W(ADDR_W)) u_addr (
    .addr    (addr),
    .org     (org),
    .lsb_in  (dq15_in),
    .word_idx(word_idx),
    .take_hi (take_hi)
  );

  rom_array #(.ADDR_W(ADDR_W)) u_array (
    .idx    (word_idx),
    .rd_word(rd_word)
  );

  rom_lane_mux u_mux (
    .word_in(rd_word),
    .org    (org),
    .take_hi(take_hi),
    .dq     (dq_out)
  );

  rom_out_gate u_gate (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .org    (org),
    .oe_vec (dq_oe),
    .standby(standby)
  );

endmodule

// File: rtl/rom_bw_port_chk.sv
module rom_bw_port_chk (
  input logic        ce_n,
  input logic        oe_n,
  input logic        word_mode,
  input logic [7:0]  dq_hi,
  input logic [15:0] dq_oe,
  input logic        standby
);

  always_comb begin
    if (!$isunknown({ce_n, oe_n, word_mode, dq_hi, dq_oe, standby})) begin
      assert_lo_whole_R3: assert (dq_oe[7:0] == 8'h00 || dq_oe[7:0] == 8'hFF)
        else $error("low lane enables split");
      assert_lo_gate_R3: assert (dq_oe[7:0] == 8'h00 || (!ce_n && !oe_n))
        else $error("low lane driven while not selected");
      assert_hi_gate_R4: assert (dq_oe[15:8] == 8'h00 || (word_mode && dq_oe[7:0] == 8'hFF))
        else $error("high lane driven outside word read");
      assert_stby_quiet_R5: assert (!standby || dq_oe == 16'h0000)
        else $error("drive during standby");
      assert_hi_blank_R2: assert (word_mode || dq_hi == 8'h00)
        else $error("upper data nonzero in byte mode");
    end
  end

endmodule

bind rom_bw_port rom_bw_port_chk u_chk (
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .word_mode(word_mode),
  .dq_hi    (dq_out[15:8]),
  .dq_oe    (dq_oe),
  .standby  (standby)
);

// File: tb/sim_rom_bw_port.sv
`timescale 1ns/1ps
module sim_rom_bw_port;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1, dq15_in = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_out, dq_oe;
  logic          standby;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rom_bw_port #(.ADDR_W(AW)) u0 (
    .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode), .addr(addr),
    .dq15_in(dq15_in), .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby)
  );

  function automatic logic [15:0] ref_word(input int a);
    int v;
    v = (a * 40503 + 4660) % 65536;
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, exp_dq, exp_oe;
    // Idle state: chip select released
    @(negedge clk); #1;
    chk("R6 idle standby", {15'b0, standby}, 16'h0001);
    chk("R5 idle drive", dq_oe, 16'h0000);

    for (int a = 0; a < (1 << AW); a++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        addr      = a[AW-1:0];
        ce_n      = c[0];
        oe_n      = c[1];
        word_mode = c[2];
        dq15_in   = c[3];
        #1; // R9: sampled in the same period, before any rising edge
        w = ref_word(a);
        if (word_mode) exp_dq = w;
        else exp_dq = dq15_in ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
        exp_oe[7:0]  = (!ce_n && !oe_n) ? 8'hFF : 8'h00;
        exp_oe[15:8] = (!ce_n && !oe_n && word_mode) ? 8'hFF : 8'h00;
        if (word_mode && dq15_in) chk("R8 R1 R9 word data", dq_out, exp_dq);
        else if (word_mode)      chk("R1 R9 word data", dq_out, exp_dq);
        else                     chk("R2 R9 byte data", dq_out, exp_dq);
        if (oe_n) chk("R7 data under gate off", dq_out, exp_dq);
        if (ce_n) chk("R5 standby drive", dq_oe, 16'h0000);
        chk("R3 low enables", {8'h00, dq_oe[7:0]}, {8'h00, exp_oe[7:0]});
        chk("R4 high enables", {8'h00, dq_oe[15:8]}, {8'h00, exp_oe[15:8]});
        chk(oe_n ? "R7 standby flag" : "R6 standby flag", {15'b0, standby}, {15'b0, ce_n});
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule